// File: doc/BRIEF.md
# LCD Link Power-Up/Power-Down Sequencer

This block is a control state machine that switches an LCD link on and off in a safe order. On the way up it raises panel power first. It then releases the serializer bridge from power-down and enables the pixel clock. Next it starts the video source with black pixels forced, switches to the real image, and turns on the backlight last. On the way down it reverses this order. The backlight goes off first and the image is held for a programmable time. Black is then forced for a counted number of frames, so that the panel never shows a torn or garbage frame. After that the bridge is put back into power-down, then the clock and video are stopped, and panel power is removed last.

All delays are counted in a free-running timing tick supplied from outside. A host programs the pixel-clock settle wait and the backlight-off wait through input ports. The panel-related limits are parameters: the minimum ramp time, the ramp timeout, the black settle time that covers bridge clock lock, and the drain frame count. The black drain is counted in frame-start pulses. A host issues single-cycle up and down requests and reads back ready, busy and fault.

Top module: `lcd_link_pwrseq`

## Requirements
- R1: After reset all six control outputs (panel, bridge, pixel clock, video, force-black, backlight), busy, ready and fault are low.
- R2: An up request while idle raises panel power only. The bridge enable rises only after RAMP_MIN_TICKS ticks have been counted in the ramp stage and panel-good is high. It is never raised while panel-good is low.
- R3: If panel-good is still low when RAMP_MAX_TICKS ticks have been counted in the ramp stage, panel power drops and the block returns idle with fault high. The next up request clears fault.
- R4: After one cycle with only panel and bridge high, the pixel clock is enabled. The clock-only stage lasts exactly the programmed clock-wait number of ticks, or a single cycle when that value is 0.
- R5: Video then starts with force-black high for BLACK_TICKS ticks. Force-black then drops for one cycle with the backlight still off, and then the backlight rises. Ready is high exactly while the backlight is on.
- R6: Busy is high in every stage except idle (all outputs low) and fully on (backlight high).
- R7: A down request while fully on drops the backlight and ready at once. The image is kept, with force-black low, for the programmed backlight-off number of ticks, or one cycle when that value is 0.
- R8: The black drain then raises force-black and stays until DRAIN_FRAMES+1 frame-start pulses have been counted in it, so that at least DRAIN_FRAMES whole black frames are sent.
- R9: After the drain, the bridge enable drops for one cycle first. Then clock, video and force-black drop for one cycle. Then panel power drops, and busy falls with it.
- R10: A down request during power-up is held until the current stage completes. After a finished ramp the block goes straight idle. After the bridge or clock stage it enters the bridge-drop step of R9. After the black or image stage it enters the drain of R8. The backlight is never raised.
- R11: An up request outside idle has no effect, and a down request while idle has no effect.
- R12: Frame-start pulses outside the drain stage do not change any stage length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timing tick, one-cycle pulse |
| frame_start_i | input | 1 | Frame-start pulse from the video timing |
| up_req_i | input | 1 | Power-up request pulse |
| down_req_i | input | 1 | Power-down request pulse |
| panel_good_i | input | 1 | Panel supply reported stable |
| clk_wait_i | input | CNT_W | Pixel-clock settle wait in ticks |
| bl_off_wait_i | input | CNT_W | Backlight-off wait in ticks |
| panel_en_o | output | 1 | Panel power enable |
| bridge_en_o | output | 1 | Bridge out of power-down |
| pclk_en_o | output | 1 | Pixel clock enable |
| video_en_o | output | 1 | Video source enable |
| force_black_o | output | 1 | Replace pixel data with black |
| backlight_en_o | output | 1 | Backlight enable |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Link fully on |
| fault_o | output | 1 | Panel ramp timed out |

## Verification
Two things can land on the same clock edge. The first is a host down request. The second is the end of a power-up stage, when the next stage is about to be entered. The bench raises the down request exactly during the single-cycle image stage. It then expects the next edge to go into the black drain rather than to full-on, with the backlight never rising. A second case raises a down request partway through the clock wait. There it checks that the stage still uses its full tick count before the teardown begins. An up request together with a down request while idle, or a down request while idle alone, is judged by the outputs staying low or following only the up path.

// File: rtl/lcd_link_pwrseq_pkg.sv
package lcd_link_pwrseq_pkg;

  typedef enum logic [3:0] {
    ST_OFF, ST_RAMP, ST_BRG, ST_CLKW, ST_BLK, ST_IMG, ST_ON,
    ST_BLOFF, ST_DRAIN, ST_BRDN, ST_VOFF
  } seq_st_e;

  typedef struct packed {
    logic panel;
    logic bridge;
    logic pclk;
    logic video;
    logic black;
    logic light;
  } link_ctl_t;

  function automatic link_ctl_t mk_ctl(input logic p, input logic b, input logic c,
                                       input logic v, input logic k, input logic l);
    return '{p, b, c, v, k, l};
  endfunction

  // stages where a held down request has been consumed
  function automatic logic is_teardown(input seq_st_e s);
    return (s == ST_OFF) || (s == ST_BLOFF) || (s == ST_DRAIN) ||
           (s == ST_BRDN) || (s == ST_VOFF);
  endfunction

endpackage

// File: rtl/lps_tick_counter.sv
module lps_tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_o <= '0;
    else if (tick && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end

  // saturation keeps long waits from wrapping to a short one
  a_r4_cnt_saturates: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == CNT_MAX && !clr) |=> (cnt_o == CNT_MAX));
endmodule

// File: rtl/lps_frame_counter.sv
module lps_frame_counter #(
  parameter int FRAMES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic frame,
  output logic done_o
);
  localparam int FR_W = $clog2(FRAMES + 2);
  localparam logic [FR_W-1:0] FR_GOAL = FR_W'(FRAMES + 1);

  logic [FR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (en && frame && cnt_q != FR_GOAL) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == FR_GOAL);

  a_r12_idle_frames_ignored: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt_q));
  a_r8_goal_holds: assert property (@(posedge clk) disable iff (rst)
    (done_o && !clr) |=> done_o);
endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
  import lcd_link_pwrseq_pkg::*;
#(
  parameter int CNT_W          = 16,
  parameter int RAMP_MIN_TICKS = 5,
  parameter int RAMP_MAX_TICKS = 100,
  parameter int BLACK_TICKS    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_req_i,
  input  logic             down_req_i,
  input  logic             panel_good_i,
  input  logic [CNT_W-1:0] clk_wait_i,
  input  logic [CNT_W-1:0] bl_off_wait_i,
  input  logic [CNT_W-1:0] dly_cnt_i,
  input  logic             frm_done_i,
  output seq_st_e          state_o,
  output logic             chg_o,
  output link_ctl_t        ctl_o,
  output logic             busy_o,
  output logic             ready_o,
  output logic             fault_o
);
  localparam logic [CNT_W-1:0] RAMP_MIN = CNT_W'(RAMP_MIN_TICKS);
  localparam logic [CNT_W-1:0] RAMP_MAX = CNT_W'(RAMP_MAX_TICKS);
  localparam logic [CNT_W-1:0] BLK_LEN  = CNT_W'(BLACK_TICKS);

  seq_st_e   st_q, st_d;
  link_ctl_t ctl_q, ctl_d;
  logic      pend_q, busy_q, ready_q, fault_q;
  logic      dn, ramp_ok, ramp_late;

  assign dn        = down_req_i | pend_q;
  assign ramp_ok   = panel_good_i && (dly_cnt_i >= RAMP_MIN);
  assign ramp_late = !panel_good_i && (dly_cnt_i >= RAMP_MAX);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:   if (up_req_i) st_d = ST_RAMP;
      ST_RAMP:  if (ramp_ok) st_d = dn ? ST_OFF : ST_BRG;
                else if (ramp_late) st_d = ST_OFF;
      ST_BRG:   st_d = dn ? ST_BRDN : ST_CLKW;
      ST_CLKW:  if (dly_cnt_i >= clk_wait_i) st_d = dn ? ST_BRDN : ST_BLK;
      ST_BLK:   if (dly_cnt_i >= BLK_LEN) st_d = dn ? ST_DRAIN : ST_IMG;
      ST_IMG:   st_d = dn ? ST_DRAIN : ST_ON;
      ST_ON:    if (dn) st_d = ST_BLOFF;
      ST_BLOFF: if (dly_cnt_i >= bl_off_wait_i) st_d = ST_DRAIN;
      ST_DRAIN: if (frm_done_i) st_d = ST_BRDN;
      ST_BRDN:  st_d = ST_VOFF;
      ST_VOFF:  st_d = ST_OFF;
      default:  st_d = ST_OFF;
    endcase
  end

  // output set for the stage being entered; teardown stages edit the live set
  always_comb begin
    ctl_d = ctl_q;
    unique case (st_d)
      ST_OFF:   ctl_d = '0;
      ST_RAMP:  ctl_d = mk_ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      ST_BRG:   ctl_d = mk_ctl(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      ST_CLKW:  ctl_d = mk_ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      ST_BLK:   ctl_d = mk_ctl(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
      ST_IMG:   ctl_d = mk_ctl(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      ST_ON:    ctl_d = mk_ctl(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
      ST_BLOFF: ctl_d.light = 1'b0;
      ST_DRAIN: ctl_d.black = 1'b1;
      ST_BRDN:  ctl_d.bridge = 1'b0;
      ST_VOFF:  begin
                  ctl_d.pclk  = 1'b0;
                  ctl_d.video = 1'b0;
                  ctl_d.black = 1'b0;
                end
      default:  ctl_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_OFF;
      ctl_q   <= '0;
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      fault_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      ctl_q   <= ctl_d;
      busy_q  <= !((st_d == ST_OFF) || (st_d == ST_ON));
      ready_q <= (st_d == ST_ON);
      if (st_q == ST_RAMP && ramp_late) fault_q <= 1'b1;
      else if (st_q == ST_OFF && up_req_i) fault_q <= 1'b0;
      if (st_q == ST_OFF || is_teardown(st_d)) pend_q <= 1'b0;
      else if (down_req_i) pend_q <= 1'b1;
    end
  end

  assign state_o = st_q;
  assign chg_o   = (st_d != st_q);
  assign ctl_o   = ctl_q;
  assign busy_o  = busy_q;
  assign ready_o = ready_q;
  assign fault_o = fault_q;

  a_r2_bridge_after_good: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_q.bridge) |-> ($past(panel_good_i) && ctl_q.panel));
  a_r5_light_on_full_link: assert property (@(posedge clk) disable iff (rst)
    ctl_q.light |-> (ctl_q.panel && ctl_q.bridge && ctl_q.pclk && ctl_q.video && !ctl_q.black));
  a_r6_ready_busy_excl: assert property (@(posedge clk) disable iff (rst)
    !(ready_q && busy_q));
  a_r8_bridge_drop_with_panel: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_q.bridge) |-> ctl_q.panel);
  a_r9_panel_last: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_q.panel) |-> $past(!ctl_q.bridge && !ctl_q.pclk && !ctl_q.video));
  a_r10_pending_never_lit: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> !ctl_q.light);
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OFF && !up_req_i) |=> (st_q == ST_OFF));
endmodule

// File: rtl/lcd_link_pwrseq.sv
module lcd_link_pwrseq
  import lcd_link_pwrseq_pkg::*;
#(
  parameter int CNT_W          = 16,
  parameter int RAMP_MIN_TICKS = 5,
  parameter int RAMP_MAX_TICKS = 100,
  parameter int BLACK_TICKS    = 10,
  parameter int DRAIN_FRAMES   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             frame_start_i,
  input  logic             up_req_i,
  input  logic             down_req_i,
  input  logic             panel_good_i,
  input  logic [CNT_W-1:0] clk_wait_i,
  input  logic [CNT_W-1:0] bl_off_wait_i,
  output logic             panel_en_o,
  output logic             bridge_en_o,
  output logic             pclk_en_o,
  output logic             video_en_o,
  output logic             force_black_o,
  output logic             backlight_en_o,
  output logic             busy_o,
  output logic             ready_o,
  output logic             fault_o
);
  seq_st_e          st;
  logic             chg, frm_done;
  logic [CNT_W-1:0] dly_cnt;
  link_ctl_t        ctl;

  lps_tick_counter #(.CNT_W(CNT_W)) u_dly (
    .clk(clk), .rst(rst), .clr(chg), .tick(tick_i), .cnt_o(dly_cnt)
  );

  lps_frame_counter #(.FRAMES(DRAIN_FRAMES)) u_frm (
    .clk(clk), .rst(rst), .clr(chg), .en(st == ST_DRAIN),
    .frame(frame_start_i), .done_o(frm_done)
  );

  lps_fsm #(
    .CNT_W(CNT_W), .RAMP_MIN_TICKS(RAMP_MIN_TICKS),
    .RAMP_MAX_TICKS(RAMP_MAX_TICKS), .BLACK_TICKS(BLACK_TICKS)
  ) u_fsm (
    .clk(clk), .rst(rst), .up_req_i(up_req_i), .down_req_i(down_req_i),
    .panel_good_i(panel_good_i), .clk_wait_i(clk_wait_i),
    .bl_off_wait_i(bl_off_wait_i), .dly_cnt_i(dly_cnt), .frm_done_i(frm_done),
    .state_o(st), .chg_o(chg), .ctl_o(ctl), .busy_o(busy_o),
    .ready_o(ready_o), .fault_o(fault_o)
  );

  assign panel_en_o     = ctl.panel;
  assign bridge_en_o    = ctl.bridge;
  assign pclk_en_o      = ctl.pclk;
  assign video_en_o     = ctl.video;
  assign force_black_o  = ctl.black;
  assign backlight_en_o = ctl.light;

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!panel_en_o && !busy_o && !ready_o && !fault_o));
endmodule

// File: tb/lcd_link_pwrseq_tb_top.sv
module lcd_link_pwrseq_tb_top;
  localparam logic [5:0] P_OFF  = 6'b000000, P_RAMP = 6'b100000, P_BRG  = 6'b110000,
                         P_CLKW = 6'b111000, P_BLK  = 6'b111110, P_IMG  = 6'b111100,
                         P_ON   = 6'b111101, P_BRDN = 6'b101110, P_BRDC = 6'b101000;

  logic clk = 1'b0, rst = 1'b1;
  logic tick_i = 1'b0, frame_i = 1'b0;
  logic up_req = 1'b0, down_req = 1'b0, panel_good = 1'b1;
  logic [15:0] clk_wait = '0, bl_wait = '0;
  logic panel, bridge, pclk, video, black, light, busy, ready, fault;
  logic [1:0] tcnt = '0;
  logic [3:0] fcnt = '0;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tcnt    <= tcnt + 2'd1;
    tick_i  <= (tcnt == 2'd3);
    fcnt    <= fcnt + 4'd1;
    frame_i <= (fcnt == 4'd9);
  end

  lcd_link_pwrseq #(.CNT_W(16), .RAMP_MIN_TICKS(5), .RAMP_MAX_TICKS(12),
                    .BLACK_TICKS(6), .DRAIN_FRAMES(2)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .frame_start_i(frame_i),
    .up_req_i(up_req), .down_req_i(down_req), .panel_good_i(panel_good),
    .clk_wait_i(clk_wait), .bl_off_wait_i(bl_wait),
    .panel_en_o(panel), .bridge_en_o(bridge), .pclk_en_o(pclk),
    .video_en_o(video), .force_black_o(black), .backlight_en_o(light),
    .busy_o(busy), .ready_o(ready), .fault_o(fault)
  );

  function automatic logic [5:0] outs();
    return {panel, bridge, pclk, video, black, light};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_pat(input logic [5:0] exp, input string req);
    chk(outs() == exp, req, int'(outs()), int'(exp));
  endtask

  // stay while the outputs show pat; count cycles, ticks and frames seen
  task automatic meas(input logic [5:0] pat, output int nt, output int nc, output int nf);
    nt = 0; nc = 0; nf = 0;
    while (outs() == pat && nc < 5000) begin
      nc++;
      if (tick_i) nt++;
      if (frame_i) nf++;
      @(negedge clk);
    end
  endtask

  task automatic wait_pat(input logic [5:0] pat);
    int n = 0;
    while (outs() != pat && n < 3000) begin n++; @(negedge clk); end
    chk(n < 3000, "wait", n, 0);
  endtask

  task automatic pulse_up();
    up_req = 1'b1; @(negedge clk); up_req = 1'b0;
  endtask

  task automatic pulse_dn();
    down_req = 1'b1; @(negedge clk); down_req = 1'b0;
  endtask

  task automatic t_reset();
    chk_pat(P_OFF, "R1 outputs");
    chk(!busy && !ready && !fault, "R1 status", {busy, ready, fault}, 0);
  endtask

  task automatic bring_up(input int cw);
    int nt, nc, nf;
    clk_wait = 16'(cw);
    pulse_up();
    chk_pat(P_RAMP, "R2 panel first");
    chk(busy, "R6 busy ramp", busy, 1);
    meas(P_RAMP, nt, nc, nf);
    chk(nt == 5, "R2 ramp ticks", nt, 5);
    chk_pat(P_BRG, "R4 bridge stage");
    meas(P_BRG, nt, nc, nf);
    chk(nc == 1, "R4 bridge cycles", nc, 1);
    chk_pat(P_CLKW, "R4 clock stage");
    meas(P_CLKW, nt, nc, nf);
    if (cw == 0) chk(nc == 1, "R4 zero wait", nc, 1);
    else chk(nt == cw, "R4 clock ticks", nt, cw);
    chk_pat(P_BLK, "R5 black video");
    meas(P_BLK, nt, nc, nf);
    chk(nt == 6, "R5 R12 black ticks with frames running", nt, 6);
    chk_pat(P_IMG, "R5 image stage");
    chk(busy && !ready, "R6 busy image", {busy, ready}, 2);
    meas(P_IMG, nt, nc, nf);
    chk(nc == 1, "R5 image cycles", nc, 1);
    chk_pat(P_ON, "R5 backlight last");
    chk(ready && !busy, "R5 R6 ready", {ready, busy}, 2);
  endtask

  task automatic bring_down(input int bw);
    int nt, nc, nf;
    bl_wait = 16'(bw);
    pulse_dn();
    chk_pat(P_IMG, "R7 backlight off first");
    chk(!ready && busy, "R7 ready drops", {ready, busy}, 1);
    meas(P_IMG, nt, nc, nf);
    if (bw == 0) chk(nc == 1, "R7 zero wait", nc, 1);
    else chk(nt == bw, "R7 backlight-off ticks", nt, bw);
    chk_pat(P_BLK, "R8 drain black");
    meas(P_BLK, nt, nc, nf);
    chk(nf == 3, "R8 drain frames", nf, 3);
    chk_pat(P_BRDN, "R9 bridge drops first");
    meas(P_BRDN, nt, nc, nf);
    chk(nc == 1, "R9 bridge-drop cycles", nc, 1);
    chk_pat(P_RAMP, "R9 video and clock off");
    @(negedge clk);
    chk_pat(P_OFF, "R9 panel last");
    chk(!busy, "R9 busy falls", busy, 0);
  endtask

  task automatic t_up_down();
    bring_up(3);
    pulse_up();
    repeat (8) @(negedge clk);
    chk_pat(P_ON, "R11 up ignored while on");
    bring_down(4);
  endtask

  task automatic t_late_good();
    int nt, nc, nf;
    panel_good = 1'b0; clk_wait = '0;
    pulse_up();
    repeat (40) @(negedge clk);
    chk_pat(P_RAMP, "R2 bridge held without panel-good");
    panel_good = 1'b1;
    @(negedge clk);
    chk_pat(P_BRG, "R2 bridge after panel-good");
    meas(P_BRG, nt, nc, nf);
    meas(P_CLKW, nt, nc, nf);
    chk(nc == 1, "R4 zero wait single cycle", nc, 1);
    wait_pat(P_ON);
    bring_down(0);
  endtask

  task automatic t_timeout_and_ramp_abort();
    int nt, nc, nf, acc;
    panel_good = 1'b0;
    pulse_up();
    meas(P_RAMP, nt, nc, nf);
    chk(nt == 12, "R3 timeout ticks", nt, 12);
    chk_pat(P_OFF, "R3 panel dropped");
    chk(fault && !busy, "R3 fault set", {fault, busy}, 2);
    pulse_dn();
    repeat (6) @(negedge clk);
    chk_pat(P_OFF, "R11 down ignored while idle");
    chk(!busy && fault, "R11 status unchanged", {busy, fault}, 1);
    panel_good = 1'b1;
    pulse_up();
    chk(!fault, "R3 fault cleared by up", fault, 0);
    acc = tick_i ? 1 : 0;
    pulse_dn();
    meas(P_RAMP, nt, nc, nf);
    chk(acc + nt == 5, "R10 ramp completes", acc + nt, 5);
    chk_pat(P_OFF, "R10 ramp abort goes idle");
  endtask

  task automatic t_down_in_clkwait();
    int nt, nc, nf, acc;
    clk_wait = 16'd8;
    pulse_up();
    wait_pat(P_CLKW);
    acc = 0;
    repeat (6) begin
      if (tick_i) acc++;
      @(negedge clk);
    end
    if (tick_i) acc++;
    pulse_dn();
    meas(P_CLKW, nt, nc, nf);
    chk(acc + nt == 8, "R10 clock stage completes", acc + nt, 8);
    chk_pat(P_BRDC, "R10 bridge drop next");
    @(negedge clk);
    chk_pat(P_RAMP, "R10 clock off");
    @(negedge clk);
    chk_pat(P_OFF, "R10 idle");
  endtask

  task automatic t_down_at_image();
    int nt, nc, nf;
    clk_wait = 16'd1;
    pulse_up();
    wait_pat(P_IMG);
    pulse_dn();
    chk_pat(P_BLK, "R10 image stage goes to drain");
    meas(P_BLK, nt, nc, nf);
    chk(nf == 3, "R8 R10 drain frames", nf, 3);
    chk_pat(P_BRDN, "R10 bridge drop after drain");
    @(negedge clk);
    chk_pat(P_RAMP, "R9 video off");
    @(negedge clk);
    chk_pat(P_OFF, "R9 idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_up_down();
    t_late_good();
    t_timeout_and_ramp_abort();
    t_down_in_clkwait();
    t_down_at_image();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule